// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit owns the HI and LO result registers of a 32-bit integer core and performs the long-latency arithmetic that targets them. A single-cycle start pulse delivers an operation code and two operands, `rs_i` and `rt_i`. These operations complete on the clock edge that accepts them:

- signed and unsigned multiplies that write the full 64-bit product to the {HI,LO} pair;
- multiply-accumulate and multiply-subtract forms that update the concatenated pair;
- direct writes of HI or LO.

A three-operand multiply and the reads of HI and LO return their value through a registered general-register result port.

Division is iterative and resolves one quotient bit per cycle. The remainder goes to HI and the quotient goes to LO. `busy_o` is high for the 32 iteration cycles. While it is high, the read ports keep showing the previous HI and LO, and any further start is dropped. A division whose divisor is zero changes nothing and does not raise busy.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, HI, LO and `gpr_o` are zero and `busy_o` and `gpr_valid_o` are low.
- R2: An accepted start with op 0 (signed) or op 1 (unsigned) writes the 64-bit product of `rs_i` and `rt_i`, upper half to HI and lower half to LO. The new value is visible right after the accepting edge.
- R3: Ops 2 and 3 (signed, unsigned) replace {HI,LO} with {HI,LO} + rs*rt. Ops 4 and 5 (signed, unsigned) replace it with {HI,LO} - rs*rt. All four work modulo 2^64 and complete on the accepting edge.
- R4: Op 6 (signed) and op 7 (unsigned) divide `rs_i` by `rt_i`. The remainder goes to HI and the quotient to LO. A signed quotient truncates toward zero, and the remainder takes the sign of the dividend. `busy_o` is high for exactly 32 cycles after the accepting edge, and the results appear as it falls.
- R5: A divide (op 6 or 7) with `rt_i` zero leaves HI and LO unchanged and does not assert `busy_o`.
- R6: A signed divide of 0x80000000 by 0xFFFFFFFF yields quotient 0x80000000 and remainder 0.
- R7: Op 12 returns the low 32 bits of the signed product on `gpr_o`, with `gpr_valid_o` high for one cycle after the accepting edge. HI and LO are unchanged.
- R8: Op 8 loads HI from `rs_i` and op 9 loads LO from `rs_i`. Op 10 returns HI and op 11 returns LO on `gpr_o`, with `gpr_valid_o` high for one cycle.
- R9: While `busy_o` is high, `hi_o`/`lo_o` show the pre-division values and any start is ignored.
- R10: Op codes 13 to 15 change nothing: HI, LO, `busy_o` and `gpr_valid_o` are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle operation request |
| op_i | input | 4 | Operation code |
| rs_i | input | 32 | First operand (dividend, move source) |
| rt_i | input | 32 | Second operand (divisor) |
| busy_o | output | 1 | Division in progress |
| hi_o | output | 32 | HI register read port |
| lo_o | output | 32 | LO register read port |
| gpr_o | output | 32 | Result for a general register |
| gpr_valid_o | output | 1 | `gpr_o` holds a fresh result |

## Verification
Multiplies, accumulates and HI/LO writes are due on the edge that accepts the start. Register-result ops are due on `gpr_o` in the cycle that follows that edge. The bench drives and samples on falling edges, so it reads those results at the first falling edge after the request. A nonzero divide raises busy at that same falling edge. The bench then counts falling edges until busy drops, expects exactly 32 of them, and compares HI and LO only after that. Checks on zero divisors, undefined codes and starts issued while busy are taken at the next falling edge, before any other request.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MULT  = 4'd0,
    OP_MULTU = 4'd1,
    OP_MADD  = 4'd2,
    OP_MADDU = 4'd3,
    OP_MSUB  = 4'd4,
    OP_MSUBU = 4'd5,
    OP_DIV   = 4'd6,
    OP_DIVU  = 4'd7,
    OP_MTHI  = 4'd8,
    OP_MTLO  = 4'd9,
    OP_MFHI  = 4'd10,
    OP_MFLO  = 4'd11,
    OP_MUL   = 4'd12
  } md_op_e;
endpackage

// File: rtl/hilo_mul.sv
module hilo_mul #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           signed_i,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] a_ext, b_ext;

  // sign-extend to full width; the low PW bits of the modular product are exact
  assign a_ext  = {{W{signed_i & a_i[W-1]}}, a_i};
  assign b_ext  = {{W{signed_i & b_i[W-1]}}, b_i};
  assign prod_o = a_ext * b_ext;
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          neg_q_q, neg_r_q;

  logic [W:0]    shifted, diff;
  logic          ge;
  logic [W-1:0]  rem_n, quo_n;

  function automatic logic [W-1:0] mag(logic [W-1:0] v, logic s);
    return (s && v[W-1]) ? -v : v;
  endfunction

  // restoring step: shift in next dividend bit, subtract if it fits
  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign ge      = ~diff[W];
  assign rem_n   = ge ? diff[W-1:0] : shifted[W-1:0];
  assign quo_n   = {quo_q[W-2:0], ge};

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
  assign quo_o  = neg_q_q ? -quo_n : quo_n;
  assign rem_o  = neg_r_q ? -rem_n : rem_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      neg_q_q <= 1'b0;
      neg_r_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= mag(dividend_i, signed_i);
      dvs_q   <= mag(divisor_i, signed_i);
      neg_q_q <= signed_i && (dividend_i[W-1] ^ divisor_i[W-1]);
      neg_r_q <= signed_i && dividend_i[W-1];
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q + 1'b1;
      if (done_o) busy_q <= 1'b0;
    end
  end

  AST_DIV_CNT_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> cnt_q == '0);                                 // R4
  AST_DIV_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);                                            // R4
  AST_DIV_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> dvs_q != '0);                                        // R5
endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
  import hilo_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    rs_i,
  input  logic [W-1:0]    rt_i,
  output logic            busy_o,
  output logic [W-1:0]    hi_o,
  output logic [W-1:0]    lo_o,
  output logic [W-1:0]    gpr_o,
  output logic            gpr_valid_o
);
  localparam int unsigned PW = 2 * W;

  md_op_e        op;
  logic          accept, is_div, div_start, mul_signed;
  logic          div_busy, div_done;
  logic [W-1:0]  div_quo, div_rem;
  logic [PW-1:0] prod, pair, pair_add, pair_sub;
  logic [W-1:0]  hi_q, lo_q, gpr_q;
  logic          gpr_vld_q;

  assign op         = md_op_e'(op_i);
  assign accept     = start_i && !div_busy;
  assign is_div     = (op == OP_DIV) || (op == OP_DIVU);
  assign div_start  = accept && is_div && (rt_i != '0);
  assign mul_signed = (op == OP_MULT) || (op == OP_MADD) ||
                      (op == OP_MSUB) || (op == OP_MUL);

  hilo_mul #(.W(W)) u_mul (
    .a_i     (rs_i),
    .b_i     (rt_i),
    .signed_i(mul_signed),
    .prod_o  (prod)
  );

  hilo_div #(.W(W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (div_start),
    .signed_i  (op == OP_DIV),
    .dividend_i(rs_i),
    .divisor_i (rt_i),
    .busy_o    (div_busy),
    .done_o    (div_done),
    .quo_o     (div_quo),
    .rem_o     (div_rem)
  );

  assign pair     = {hi_q, lo_q};
  assign pair_add = pair + prod;
  assign pair_sub = pair - prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (div_done) begin
      hi_q <= div_rem;
      lo_q <= div_quo;
    end else if (accept) begin
      unique case (op)
        OP_MULT, OP_MULTU: {hi_q, lo_q} <= prod;
        OP_MADD, OP_MADDU: {hi_q, lo_q} <= pair_add;
        OP_MSUB, OP_MSUBU: {hi_q, lo_q} <= pair_sub;
        OP_MTHI:           hi_q <= rs_i;
        OP_MTLO:           lo_q <= rs_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gpr_q     <= '0;
      gpr_vld_q <= 1'b0;
    end else begin
      gpr_vld_q <= 1'b0;
      if (accept) begin
        unique case (op)
          OP_MUL:  begin gpr_q <= prod[W-1:0]; gpr_vld_q <= 1'b1; end
          OP_MFHI: begin gpr_q <= hi_q;        gpr_vld_q <= 1'b1; end
          OP_MFLO: begin gpr_q <= lo_q;        gpr_vld_q <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  assign busy_o      = div_busy;
  assign hi_o        = hi_q;
  assign lo_o        = lo_q;
  assign gpr_o       = gpr_q;
  assign gpr_valid_o = gpr_vld_q;

  AST_HILO_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !div_done |=> $stable(hi_q) && $stable(lo_q));        // R9
  AST_DIV_ZERO_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && (op_i == 4'd6 || op_i == 4'd7) && rt_i == '0
    |=> !busy_o && $stable(hi_q) && $stable(lo_q));                 // R5
  AST_GPR_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_valid_o |-> $past(start_i) && !$past(busy_o));              // R7
  AST_UNDEF_OP_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && op_i > 4'd12
    |=> $stable(hi_q) && $stable(lo_q) && !gpr_valid_o && !busy_o); // R10
endmodule

// File: tb/sim_hilo_muldiv_unit.sv
module sim_hilo_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] rs = '0, rt = '0;
  logic        busy, gpr_valid;
  logic [31:0] hi, lo, gpr;

  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  hilo_muldiv_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .rs_i(rs), .rt_i(rt), .busy_o(busy), .hi_o(hi), .lo_o(lo),
    .gpr_o(gpr), .gpr_valid_o(gpr_valid)
  );

  logic [31:0] vals [12] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h7, 32'hFFFFFFFF,
                             32'hFFFFFFFE, 32'h80000000, 32'h7FFFFFFF,
                             32'h12345678, 32'hDEADBEEF, 32'h00010000};

  function automatic logic [63:0] sx(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [3:0] o, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = o; rs = a; rt = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic set_hilo(logic [31:0] h, logic [31:0] l);
    issue(4'd8, h, 32'h0);
    issue(4'd9, l, 32'h0);
  endtask

  task automatic wait_div(output int n);
    n = 0;
    while (busy && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [63:0] exp, base;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hilo", {hi, lo}, 64'h0);
    chk("R1 gpr", {31'h0, busy, gpr_valid, gpr}, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        logic [31:0] a, b;
        a = vals[i]; b = vals[j];
        // R2 products
        issue(4'd0, a, b);
        chk("R2 mult", {hi, lo}, sx(a) * sx(b));
        issue(4'd1, a, b);
        chk("R2 multu", {hi, lo}, {32'h0, a} * {32'h0, b});
        // R3 accumulate
        base = {vals[(i + j) % 12], vals[(i + 5) % 12]};
        set_hilo(base[63:32], base[31:0]);
        chk("R8 mthi/mtlo", {hi, lo}, base);
        issue(4'd2, a, b);
        exp = base + sx(a) * sx(b);
        chk("R3 madd", {hi, lo}, exp);
        issue(4'd3, a, b);
        exp = exp + {32'h0, a} * {32'h0, b};
        chk("R3 maddu", {hi, lo}, exp);
        issue(4'd4, a, b);
        exp = exp - sx(a) * sx(b);
        chk("R3 msub", {hi, lo}, exp);
        issue(4'd5, a, b);
        exp = exp - {32'h0, a} * {32'h0, b};
        chk("R3 msubu", {hi, lo}, exp);
        // R7 gpr multiply
        issue(4'd12, a, b);
        base = sx(a) * sx(b);
        chk("R7 mul", {31'h0, gpr_valid, gpr}, {31'h0, 1'b1, base[31:0]});
        chk("R7 hilo kept", {hi, lo}, exp);
        // R8 reads
        issue(4'd10, 32'h0, 32'h0);
        chk("R8 mfhi", {31'h0, gpr_valid, gpr}, {31'h0, 1'b1, exp[63:32]});
        issue(4'd11, 32'h0, 32'h0);
        chk("R8 mflo", {31'h0, gpr_valid, gpr}, {31'h0, 1'b1, exp[31:0]});
        // R4 / R5 / R6 divides
        for (int s = 0; s < 2; s++) begin
          set_hilo(32'hA5A5A5A5, 32'h5A5A5A5A);
          issue(s ? 4'd7 : 4'd6, a, b);
          if (b == 32'h0) begin
            chk("R5 no busy", {63'h0, busy}, 64'h0);
            chk("R5 hilo kept", {hi, lo}, 64'hA5A5A5A55A5A5A5A);
          end else begin
            longint sa, sb, q, r;
            sa = s ? longint'({32'h0, a}) : longint'(sx(a));
            sb = s ? longint'({32'h0, b}) : longint'(sx(b));
            q = sa / sb; r = sa % sb;
            chk("R4 busy", {63'h0, busy}, 64'h1);
            wait_div(n);
            chk("R4 busy cycles", 64'(n), 64'd32);
            if (!s && a == 32'h80000000 && b == 32'hFFFFFFFF)
              chk("R6 overflow", {hi, lo}, 64'h0000000080000000);
            else
              chk("R4 div", {hi, lo}, {r[31:0], q[31:0]});
          end
        end
      end
    end

    // R9 reads and starts during busy
    set_hilo(32'h11111111, 32'h22222222);
    issue(4'd6, 32'd100, 32'd7);
    repeat (3) @(negedge clk);
    chk("R9 hi old", {hi, lo}, 64'h1111111122222222);
    issue(4'd8, 32'hDEADDEAD, 32'h0);
    chk("R9 still busy", {63'h0, busy}, 64'h1);
    issue(4'd12, 32'd3, 32'd3);
    chk("R9 mul dropped", {63'h0, gpr_valid}, 64'h0);
    wait_div(n);
    chk("R9 result", {hi, lo}, {32'd2, 32'd14});

    // R10 undefined codes
    for (int c = 13; c < 16; c++) begin
      issue(4'(c), 32'hFFFF0000, 32'h3);
      chk("R10 hilo", {hi, lo}, {32'd2, 32'd14});
      chk("R10 flags", {62'h0, busy, gpr_valid}, 64'h0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule